// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital controller of a 10-bit successive-approximation analog-to-digital converter with four multiplexed inputs. It takes its settings as plain configuration pins: a converter enable, a 2-bit input select, a reference select, a 3-bit conversion-clock select and a result-format bit. A one-cycle start strobe launches a conversion. The busy flag then stays high until the result is stored, or until the conversion is aborted.

During a conversion the block does the following:
- It divides the system clock (or counts ticks of a slow internal oscillator) to form the conversion-clock period.
- It holds the input mux select and the reference select steady, and asserts the sample-and-hold control.
- It steps a trial code, MSB first, on the DAC code output and reads back one comparator decision per period.

The finished code goes into a result register. That register is shown as a high byte and a low byte in the chosen justification. The comparator, the DAC, the sample-and-hold and the pin buffers sit outside the block.

Software must pick a clock source whose period is at least 1.6 µs for a correct conversion; the block does not check this. Every interface here is a control or status pin. There is no streaming interface, so no back-pressure applies.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, busy_o, sh_hold_o, dac_code_o, res_hi_o and res_lo_o are all zero.
- R2: A start_i pulse sampled while en_i is high and busy_o is low sets busy_o at the next clock edge. sh_hold_o equals busy_o at all times.
- R3: A start_i pulse sampled while en_i is low has no effect: busy_o stays low.
- R4: A start_i pulse sampled while busy_o is high has no effect: the conversion ends at the same cycle it would have ended without the pulse.
- R5: The conversion-clock period is 2^(clk_sel_i+1) system clocks for clk_sel_i codes 0 to 5, and one rc_tick_i pulse for codes 6 and 7. A conversion lasts exactly 11 periods, so with a divided clock busy_o is high for 11·2^(clk_sel_i+1) cycles.
- R6: At the end of period 1, dac_code_o becomes 10'h200. At the end of each of periods 2 to 11, the trial bit is kept if cmp_i is 1 or cleared if cmp_i is 0, and the next lower bit is set, MSB first. The comparator polarity is cmp_i = 1 when the input is at or above the DAC level.
- R7: The result register takes the final code at the same edge that clears busy_o.
- R8: With left_just_i = 1, res_hi_o = result[9:2] and res_lo_o = {result[1:0], 6'b0}. With left_just_i = 0, res_hi_o = {6'b0, result[9:8]} and res_lo_o = result[7:0]. Unused bits read as zero.
- R9: en_i low while busy_o is high aborts the conversion: busy_o clears at the next edge and the result register is left unchanged.
- R10: While idle, mux_sel_o and ref_sel_o follow chan_sel_i and ref_ext_i. While busy, they hold the values sampled when the start was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Converter enable; low aborts a conversion |
| start_i | input | 1 | Start request strobe |
| chan_sel_i | input | 2 | Analog input select |
| ref_ext_i | input | 1 | 1 = external reference pin, 0 = supply rail |
| clk_sel_i | input | 3 | Conversion-clock source code |
| left_just_i | input | 1 | Result format: 1 = left, 0 = right justified |
| rc_tick_i | input | 1 | One-cycle tick from the internal oscillator, already synchronous |
| cmp_i | input | 1 | Comparator decision for the current trial code |
| busy_o | output | 1 | Conversion in progress (start/busy flag) |
| mux_sel_o | output | 2 | Analog mux select |
| ref_sel_o | output | 1 | Reference select to the DAC |
| sh_hold_o | output | 1 | Sample-and-hold in hold mode |
| dac_code_o | output | 10 | Trial code to the DAC |
| res_hi_o | output | 8 | Result high byte |
| res_lo_o | output | 8 | Result low byte |

## Verification
Three cases are hardest to reach from the ports: an abort that lands in the middle of a bit trial, a repeated start during a conversion, and a channel change partway through. Each needs an input that moves at a chosen cycle inside a long conversion. The stimulus counts cycles from the accepted start and changes en_i, start_i or chan_sel_i at a set offset. Meanwhile a comparator model answers against a per-channel analog value. Because of that, any use of the live channel instead of the latched one would show up as a wrong code.

// File: rtl/sar_pkg.sv
package sar_pkg;

  localparam int unsigned CH_W  = 2;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    CK_DIV2  = 3'd0,
    CK_DIV4  = 3'd1,
    CK_DIV8  = 3'd2,
    CK_DIV16 = 3'd3,
    CK_DIV32 = 3'd4,
    CK_DIV64 = 3'd5,
    CK_RC    = 3'd6,
    CK_RC2   = 3'd7
  } clk_src_e;

  typedef struct packed {
    logic [CH_W-1:0]  chan;
    logic             ref_ext;
    logic [SEL_W-1:0] clk_sel;
  } conv_cfg_t;

  function automatic logic src_is_rc(logic [SEL_W-1:0] sel);
    return sel >= SEL_W'(CK_RC);
  endfunction

endpackage

// File: rtl/sar_clkgen.sv
module sar_clkgen
  import sar_pkg::*;
#(
  parameter int unsigned MAX_EXP = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rc_tick_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = MAX_EXP;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] lim;

  always_comb begin
    int unsigned shamt;
    shamt = int'(sel_i) + 1;
    if (shamt > MAX_EXP) shamt = MAX_EXP;
    lim = DIV_W'((64'd1 << shamt) - 64'd1);
  end

  assign tick_o = run_i && (src_is_rc(sel_i) ? rc_tick_i : (div_q == lim));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else if (restart_i || !run_i || tick_o) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  // R5
  div_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !src_is_rc(sel_i)) |=> !tick_o);

endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             abort_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [RES_W-1:0] code_o,
  output logic [RES_W-1:0] final_o
);
  localparam int unsigned PER_W = $clog2(RES_W + 1);
  localparam logic [RES_W-1:0] FIRST_TRIAL = RES_W'(1) << (RES_W - 1);

  logic             busy_q;
  logic [PER_W-1:0] per_q;
  logic [RES_W-1:0] sar_q;
  logic [RES_W-1:0] nxt;

  always_comb begin
    int bidx;
    bidx = int'(RES_W) - int'(per_q);
    nxt  = sar_q;
    for (int i = 0; i < int'(RES_W); i++) begin
      if (i == bidx && !cmp_i) nxt[i] = 1'b0;
      if (i + 1 == bidx)       nxt[i] = 1'b1;
    end
  end

  assign done_o  = busy_q && tick_i && (per_q == PER_W'(RES_W));
  assign busy_o  = busy_q;
  assign code_o  = sar_q;
  assign final_o = nxt;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      per_q  <= '0;
      sar_q  <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      per_q  <= '0;
    end else if (launch_i) begin
      busy_q <= 1'b1;
      per_q  <= '0;
      sar_q  <= '0;
    end else if (busy_q && tick_i) begin
      if (per_q == '0) begin
        sar_q <= FIRST_TRIAL;
      end else begin
        sar_q <= nxt;
      end
      per_q <= per_q + 1'b1;
      if (done_o) busy_q <= 1'b0;
    end
  end

  // R6
  first_trial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && tick_i && !abort_i && per_q == '0) |=> (sar_q == FIRST_TRIAL));

  // R5
  period_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (per_q <= PER_W'(RES_W)));

endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int unsigned RES_W = 10,
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [RES_W-1:0] data_i,
  input  logic             left_i,
  output logic [REG_W-1:0] hi_o,
  output logic [REG_W-1:0] lo_o
);
  localparam int unsigned PAIR_W = 2 * REG_W;
  localparam int unsigned PAD    = PAIR_W - RES_W;

  logic [RES_W-1:0]  res_q;
  logic [PAIR_W-1:0] pair;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   res_q <= '0;
    else if (wr_i) res_q <= data_i;
  end

  always_comb begin
    if (left_i) pair = PAIR_W'(res_q) << PAD;
    else        pair = PAIR_W'(res_q);
  end

  assign hi_o = pair[PAIR_W-1:REG_W];
  assign lo_o = pair[REG_W-1:0];

  // R7
  result_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (res_q == $past(data_i)));

  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(res_q));

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_pkg::*;
#(
  parameter int unsigned RES_W   = 10,
  parameter int unsigned REG_W   = 8,
  parameter int unsigned MAX_EXP = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [1:0]       chan_sel_i,
  input  logic             ref_ext_i,
  input  logic [2:0]       clk_sel_i,
  input  logic             left_just_i,
  input  logic             rc_tick_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic [1:0]       mux_sel_o,
  output logic             ref_sel_o,
  output logic             sh_hold_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic [REG_W-1:0] res_hi_o,
  output logic [REG_W-1:0] res_lo_o
);
  conv_cfg_t        cfg_q;
  logic             busy;
  logic             launch;
  logic             abort;
  logic             tick;
  logic             done;
  logic [RES_W-1:0] final_code;

  assign launch = start_i && en_i && !busy;
  assign abort  = busy && !en_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (launch) begin
      cfg_q.chan    <= chan_sel_i;
      cfg_q.ref_ext <= ref_ext_i;
      cfg_q.clk_sel <= clk_sel_i;
    end
  end

  sar_clkgen #(.MAX_EXP(MAX_EXP)) clkgen_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy && en_i),
    .restart_i (launch),
    .sel_i     (cfg_q.clk_sel),
    .rc_tick_i (rc_tick_i),
    .tick_o    (tick)
  );

  sar_engine #(.RES_W(RES_W)) engine_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .abort_i  (abort),
    .tick_i   (tick),
    .cmp_i    (cmp_i),
    .busy_o   (busy),
    .done_o   (done),
    .code_o   (dac_code_o),
    .final_o  (final_code)
  );

  sar_result #(.RES_W(RES_W), .REG_W(REG_W)) result_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (done),
    .data_i (final_code),
    .left_i (left_just_i),
    .hi_o   (res_hi_o),
    .lo_o   (res_lo_o)
  );

  assign busy_o    = busy;
  assign sh_hold_o = busy;
  assign mux_sel_o = busy ? cfg_q.chan    : chan_sel_i;
  assign ref_sel_o = busy ? cfg_q.ref_ext : ref_ext_i;

  // R3
  start_no_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !en_i) |=> !busy_o);

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && en_i) |=> busy_o);

  // R4
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && en_i && start_i && !done) |=> busy_o);

  // R9
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !en_i) |=> (!busy_o && (!$stable(left_just_i) || $stable({res_hi_o, res_lo_o}))));

  // R10
  mux_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(mux_sel_o) && $stable(ref_sel_o)));

endmodule

// File: tb/sar_adc_seq_tb.sv
module sar_adc_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       start = 1'b0;
  logic [1:0] chan = 2'd0;
  logic       ref_ext = 1'b0;
  logic [2:0] csel = 3'd0;
  logic       ljust = 1'b0;
  logic       rc_tick = 1'b0;
  logic       rc_on = 1'b0;
  logic       cmp;
  logic       busy, ref_sel, hold;
  logic [1:0] mux_sel;
  logic [9:0] dac;
  logic [7:0] hi, lo;
  int         ana [4];

  int tests = 0, fails = 0, cyc = 0;
  int chk_on = 0;
  int done_flag = 0;

  int m_busy, m_el, m_ticks, m_res, m_chan, m_ref, m_sel;

  always #4 clk = ~clk;

  assign cmp = (ana[mux_sel] >= int'(dac));

  sar_adc_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start),
    .chan_sel_i(chan), .ref_ext_i(ref_ext), .clk_sel_i(csel),
    .left_just_i(ljust), .rc_tick_i(rc_tick), .cmp_i(cmp),
    .busy_o(busy), .mux_sel_o(mux_sel), .ref_sel_o(ref_sel),
    .sh_hold_o(hold), .dac_code_o(dac), .res_hi_o(hi), .res_lo_o(lo)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_code(int v, int k);
    int mask;
    if (k == 0) return 0;
    mask = 1023 & ~((1 << (11 - k)) - 1);
    return (v & mask) | (1 << (10 - k));
  endfunction

  function automatic int exp_hi(int r, int lj);
    return lj ? (r >> 2) : (r >> 8);
  endfunction

  function automatic int exp_lo(int r, int lj);
    return lj ? ((r & 3) << 6) : (r & 255);
  endfunction

  // behavioural reference model, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_el = 0; m_ticks = 0; m_res = 0;
      m_chan = 0; m_ref = 0; m_sel = 0;
    end else if (m_busy != 0) begin
      if (!en) begin
        m_busy = 0;
      end else begin
        m_el++;
        if (m_sel >= 6 ? (rc_tick == 1'b1) : ((m_el % (2 << m_sel)) == 0)) begin
          m_ticks++;
          if (m_ticks == 11) begin
            m_busy = 0;
            m_res  = ana[m_chan];
          end
        end
      end
    end else if (start && en) begin
      m_busy = 1; m_el = 0; m_ticks = 0;
      m_chan = int'(chan); m_ref = int'(ref_ext); m_sel = int'(csel);
    end
    if (cyc > 150000 && done_flag == 0) begin
      done_flag = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // compare against the model on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && chk_on != 0) begin
      chk("R5 busy", int'(busy), m_busy);
      chk("R2 hold", int'(hold), m_busy);
      chk("R10 mux", int'(mux_sel), m_busy != 0 ? m_chan : int'(chan));
      chk("R10 ref", int'(ref_sel), m_busy != 0 ? m_ref : int'(ref_ext));
      chk("R8 hi", int'(hi), exp_hi(m_res, int'(ljust)));
      chk("R8 lo", int'(lo), exp_lo(m_res, int'(ljust)));
      if (m_busy != 0) chk("R6 dac", int'(dac), exp_code(ana[m_chan], m_ticks));
    end
    rc_tick <= rc_on && ((cyc % 5) == 2);
  end

  // runs one conversion; inj/abort_at/swap_at are cycle offsets, -1 = unused
  task automatic conv(int sel, int ch, int lj, int rx, int inj, int abort_at, int swap_at);
    int cnt;
    int prev_res;
    prev_res = m_res;
    @(negedge clk);
    csel = 3'(sel); chan = 2'(ch); ljust = lj[0]; ref_ext = rx[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", int'(busy), 1);
    cnt = 0;
    while (busy && cnt < 5000) begin
      cnt++;
      start = (cnt == inj);
      if (cnt == swap_at) chan = chan + 2'd1;
      if (cnt == abort_at) en = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    if (abort_at > 0) begin
      chk("R9 abort stops at once", cnt, abort_at);
      chk("R9 result unchanged", int'({hi, lo}),
          (exp_hi(prev_res, lj) << 8) | exp_lo(prev_res, lj));
      en = 1'b1;
    end else begin
      if (sel < 6) chk("R5 duration", cnt, 11 * (2 << sel));
      chk("R7 result", int'({hi, lo}), (exp_hi(ana[ch], lj) << 8) | exp_lo(ana[ch], lj));
    end
  endtask

  initial begin
    ana[0] = 727; ana[1] = 0; ana[2] = 1023; ana[3] = 512;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 hold", int'(hold), 0);
    chk("R1 dac", int'(dac), 0);
    chk("R1 hi", int'(hi), 0);
    chk("R1 lo", int'(lo), 0);
    chk_on = 1;

    // R3: start with the converter disabled
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R3 start ignored", int'(busy), 0);
    en = 1'b1;
    @(negedge clk);

    // R5/R6/R7: every divided source, varied values and channels
    for (int s = 0; s < 6; s++) conv(s, s % 4, s % 2, s % 2, -1, -1, -1);
    ana[1] = 511; ana[3] = 341;
    conv(0, 1, 0, 0, -1, -1, -1);
    conv(1, 3, 1, 1, -1, -1, -1);
    ana[0] = 682;
    conv(0, 0, 0, 0, -1, -1, -1);

    // R5: internal oscillator source, codes 6 and 7
    rc_on = 1'b1;
    conv(6, 2, 0, 1, -1, -1, -1);
    conv(7, 0, 1, 0, -1, -1, -1);
    rc_on = 1'b0;

    // R8: format bit changes how the stored result reads
    @(negedge clk);
    ljust = 1'b1;
    @(negedge clk);
    chk("R8 left hi", int'(hi), ana[0] >> 2);
    chk("R8 left lo", int'(lo), (ana[0] & 3) << 6);
    ljust = 1'b0;
    @(negedge clk);
    chk("R8 right hi", int'(hi), ana[0] >> 8);
    chk("R8 right lo", int'(lo), ana[0] & 255);

    // R4: second start in mid conversion
    conv(1, 3, 0, 0, 13, -1, -1);
    // R10: channel change mid conversion, result from latched channel
    conv(2, 1, 1, 0, -1, -1, 30);
    // R9: abort in the middle of a trial
    conv(2, 2, 0, 1, -1, 37, -1);
    conv(0, 2, 0, 0, -1, 5, -1);
    // conversion after an abort completes normally
    conv(0, 3, 1, 0, -1, -1, -1);

    repeat (4) @(negedge clk);
    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule